// File: doc/BRIEF.md
# Privilege Check and Trap Entry Stage

This stage sits after instruction decode. For each issued operation it receives the operation class, the high bit of the special-register number, an illegal-instruction flag, the address of the current instruction and the 64-bit machine state word. It decides whether the operation proceeds, traps to the program-check vector for a privilege or illegal-instruction cause, or stops the machine.

On a trap the stage produces three things. The saved-address value is the current instruction address. The saved-state value is the incoming machine state with the cause bit forced on. The rewritten machine state drops the stage into supervisor, big-address, little-endian mode with relocation, interrupts and the optional units off. The next fetch address is the fixed program-check vector.

Without a trap the next address is the sequential one and the state words pass through unchanged. A non-trapped attention operation sets a sticky halted flag, and after that every later issue is ignored until reset. Results are registered and appear one clock after the issue.

Top module: `trap_gate`

## Requirements
- R1: After reset, res_valid, trap, trap_cause, halted, nia, msr_out, save_addr and save_state are all zero.
- R2: Opcode classes use these op_class encodings: 0 other, 1 attention, 2 read-state, 3 write-state, 4 write-state-doubleword, 5 return-from-interrupt, 6 read-special, 7 write-special. Classes 1 to 5 are privileged. When a privileged class issues while machine state bit 14 (problem state) is 1, the stage traps with trap_cause = 2'b01 (privilege), and bit 18 of save_state is 1.
- R3: Classes 6 and 7 are privileged only when spr_hi is 1. With spr_hi = 0 they never trap for privilege.
- R4: An issue with illegal = 1 that is not a privilege trap traps with trap_cause = 2'b10, and bit 19 of save_state is 1. A privilege trap takes priority, so only bit 18 is forced and bit 19 is copied from msr_in.
- R5: On a trap, save_addr equals cia, and save_state equals msr_in with the cause bit forced to 1.
- R6: On a trap, nia is 0x700.
- R7: On a trap, msr_out equals msr_in with these bits cleared: 1, 2, 4, 5, 8, 9, 10, 11, 13, 14, 15, 23, 25, 32 and 58. Bits 63 (64-bit mode) and 0 (little-endian) are set to 1. All other bits are copied.
- R8: Without a trap or halt, nia is cia + 4, msr_out equals msr_in, and save_addr and save_state keep their previous values.
- R9: An attention operation (class 1) issued with problem state 0 sets halted. This happens even when illegal is 1. nia is then cia, and there is no trap.
- R10: While halted is 1, issues are ignored. res_valid stays 0, all outputs hold their values, and only reset clears halted.
- R11: All outputs are registered. res_valid is 1 for exactly the one cycle after an accepted issue and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An operation is presented this cycle |
| op_class | input | 4 | Decoded operation class |
| spr_hi | input | 1 | High bit of the special-register number |
| illegal | input | 1 | Decoder flags the instruction as illegal |
| cia | input | 64 | Current instruction address |
| msr_in | input | 64 | Current machine state word |
| res_valid | output | 1 | One-cycle strobe for a completed decision |
| trap | output | 1 | Last decision was a trap |
| trap_cause | output | 2 | Bit 0 privilege, bit 1 illegal |
| halted | output | 1 | Sticky stop flag |
| nia | output | 64 | Next instruction address |
| msr_out | output | 64 | Machine state after the operation |
| save_addr | output | 64 | Saved return address |
| save_state | output | 64 | Saved machine state with cause bit |

## Verification
The bench targets the points where priority and qualification interact. A privileged operation that is also flagged illegal must report only the privilege cause; getting the order wrong would force bit 19 and report the wrong cause. The special-register moves are exercised with spr_hi both clear and set, to catch a design that treats them as always or never privileged. An attention operation in problem state must trap rather than halt, and a halted stage is fed more operations to show that nothing changes. Machine-state words with alternating bit patterns expose any single misplaced clear or set bit in the rewrite.

// File: rtl/trap_gate_pkg.sv
package trap_gate_pkg;

    localparam int XLEN = 64;

    typedef enum logic [3:0] {
        OPC_OTHER   = 4'd0,
        OPC_ATTN    = 4'd1,
        OPC_RDSTATE = 4'd2,
        OPC_WRSTATE = 4'd3,
        OPC_WRSTDW  = 4'd4,
        OPC_RETINT  = 4'd5,
        OPC_RDSPEC  = 4'd6,
        OPC_WRSPEC  = 4'd7
    } op_class_e;

    // machine state bit positions (bit 0 = least significant)
    localparam int ST_LE   = 0;
    localparam int ST_RI   = 1;
    localparam int ST_PMM  = 2;
    localparam int ST_DR   = 4;
    localparam int ST_IR   = 5;
    localparam int ST_FE1  = 8;
    localparam int ST_TEE  = 9;
    localparam int ST_TES  = 10;
    localparam int ST_FE0  = 11;
    localparam int ST_FP   = 13;
    localparam int ST_PR   = 14;
    localparam int ST_EE   = 15;
    localparam int ST_VSX  = 23;
    localparam int ST_VEC  = 25;
    localparam int ST_TM   = 32;
    localparam int ST_UND  = 58;
    localparam int ST_SF   = 63;

    // cause positions inside the saved state word
    localparam int CAUSE_PRIV_BIT = 18;
    localparam int CAUSE_ILL_BIT  = 19;

    function automatic logic [XLEN-1:0] clear_mask();
        logic [XLEN-1:0] m;
        m = '0;
        m[ST_IR]  = 1'b1;
        m[ST_DR]  = 1'b1;
        m[ST_FE0] = 1'b1;
        m[ST_FE1] = 1'b1;
        m[ST_EE]  = 1'b1;
        m[ST_RI]  = 1'b1;
        m[ST_TM]  = 1'b1;
        m[ST_VEC] = 1'b1;
        m[ST_VSX] = 1'b1;
        m[ST_PR]  = 1'b1;
        m[ST_FP]  = 1'b1;
        m[ST_PMM] = 1'b1;
        m[ST_TES] = 1'b1;
        m[ST_TEE] = 1'b1;
        m[ST_UND] = 1'b1;
        return m;
    endfunction

    function automatic logic [XLEN-1:0] set_mask();
        logic [XLEN-1:0] m;
        m = '0;
        m[ST_SF] = 1'b1;
        m[ST_LE] = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic            res_valid;
        logic            trap;
        logic [1:0]      cause;
        logic            halted;
        logic [XLEN-1:0] nia;
        logic [XLEN-1:0] msr;
        logic [XLEN-1:0] save_addr;
        logic [XLEN-1:0] save_state;
    } gate_state_t;

endpackage

// File: rtl/trap_priv_classify.sv
module trap_priv_classify
    import trap_gate_pkg::*;
(
    input  logic [3:0] op_class,
    input  logic       spr_hi,
    output logic       is_priv,
    output logic       is_attn
);
    always_comb begin
        is_attn = (op_class == OPC_ATTN);
        case (op_class)
            OPC_ATTN, OPC_RDSTATE, OPC_WRSTATE, OPC_WRSTDW, OPC_RETINT:
                is_priv = 1'b1;
            OPC_RDSPEC, OPC_WRSPEC:
                is_priv = spr_hi;
            default:
                is_priv = 1'b0;
        endcase
    end

    always_comb begin
        assert_spec_qual_R3: assert (!((op_class == OPC_RDSPEC || op_class == OPC_WRSPEC)
                                       && !spr_hi && is_priv))
            else $error("special move privileged without high bit");
    end
endmodule

// File: rtl/trap_state_rewrite.sv
module trap_state_rewrite
    import trap_gate_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] state_in,
    input  logic [1:0]   cause,
    output logic [W-1:0] state_new,
    output logic [W-1:0] state_saved
);
    localparam logic [XLEN-1:0] CLR = clear_mask();
    localparam logic [XLEN-1:0] SET = set_mask();

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (SET[b]) begin : g_set
            assign state_new[b] = 1'b1;
        end else if (CLR[b]) begin : g_clr
            assign state_new[b] = 1'b0;
        end else begin : g_keep
            assign state_new[b] = state_in[b];
        end

        if (b == CAUSE_PRIV_BIT) begin : g_cp
            assign state_saved[b] = state_in[b] | cause[0];
        end else if (b == CAUSE_ILL_BIT) begin : g_ci
            assign state_saved[b] = state_in[b] | cause[1];
        end else begin : g_cc
            assign state_saved[b] = state_in[b];
        end
    end
endmodule

// File: rtl/trap_gate.sv
module trap_gate
    import trap_gate_pkg::*;
#(
    parameter logic [XLEN-1:0] TRAP_VECTOR = 64'h700,
    parameter int              INSN_BYTES  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic [3:0]      op_class,
    input  logic            spr_hi,
    input  logic            illegal,
    input  logic [XLEN-1:0] cia,
    input  logic [XLEN-1:0] msr_in,
    output logic            res_valid,
    output logic            trap,
    output logic [1:0]      trap_cause,
    output logic            halted,
    output logic [XLEN-1:0] nia,
    output logic [XLEN-1:0] msr_out,
    output logic [XLEN-1:0] save_addr,
    output logic [XLEN-1:0] save_state
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    gate_state_t st_d, st_q;

    logic            is_priv, is_attn;
    logic            priv_trap, ill_trap, go_halt;
    logic [1:0]      cause_d;
    logic [XLEN-1:0] rewritten, saved;

    trap_priv_classify u_class (
        .op_class (op_class),
        .spr_hi   (spr_hi),
        .is_priv  (is_priv),
        .is_attn  (is_attn)
    );

    trap_state_rewrite #(.W(XLEN)) u_rewrite (
        .state_in    (msr_in),
        .cause       (cause_d),
        .state_new   (rewritten),
        .state_saved (saved)
    );

    always_comb begin
        priv_trap = is_priv && msr_in[ST_PR];
        go_halt   = !priv_trap && is_attn;
        ill_trap  = !priv_trap && !go_halt && illegal;
        cause_d   = {ill_trap, priv_trap};

        st_d           = st_q;
        st_d.res_valid = 1'b0;
        if (issue_valid && !st_q.halted) begin
            st_d.res_valid = 1'b1;
            st_d.trap      = priv_trap || ill_trap;
            st_d.cause     = cause_d;
            if (priv_trap || ill_trap) begin
                st_d.nia        = TRAP_VECTOR;
                st_d.msr        = rewritten;
                st_d.save_addr  = cia;
                st_d.save_state = saved;
            end else if (go_halt) begin
                st_d.halted = 1'b1;
                st_d.nia    = cia;
                st_d.msr    = msr_in;
            end else begin
                st_d.nia = cia + STEP;
                st_d.msr = msr_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid  = st_q.res_valid;
    assign trap       = st_q.trap;
    assign trap_cause = st_q.cause;
    assign halted     = st_q.halted;
    assign nia        = st_q.nia;
    assign msr_out    = st_q.msr;
    assign save_addr  = st_q.save_addr;
    assign save_state = st_q.save_state;

    // checks
    assert_cause_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trap_cause));

    assert_trap_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && trap) |-> (nia == TRAP_VECTOR));

    assert_trap_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && trap) |-> (!msr_out[ST_PR] && msr_out[ST_SF] && msr_out[ST_LE]
                                 && !msr_out[ST_EE]));

    assert_saved_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !halted && (is_priv && msr_in[ST_PR])) |=>
            (trap && trap_cause == 2'b01 && save_addr == $past(cia)));

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !res_valid));

    assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !halted) |=> res_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !trap) |-> $stable(save_addr));
endmodule

// File: tb/trap_gate_tb_top.sv
module trap_gate_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [63:0] CLR = 64'h0400_0001_0280_EF36;
    localparam logic [63:0] SET = 64'h8000_0000_0000_0001;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        issue_valid = 0;
    logic [3:0]  op_class = 0;
    logic        spr_hi = 0;
    logic        illegal = 0;
    logic [63:0] cia = 0;
    logic [63:0] msr_in = 0;
    logic        res_valid, trap, halted;
    logic [1:0]  trap_cause;
    logic [63:0] nia, msr_out, save_addr, save_state;

    int n_checks = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_gate dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op_class(op_class),
        .spr_hi(spr_hi), .illegal(illegal), .cia(cia), .msr_in(msr_in),
        .res_valid(res_valid), .trap(trap), .trap_cause(trap_cause), .halted(halted),
        .nia(nia), .msr_out(msr_out), .save_addr(save_addr), .save_state(save_state)
    );

    // {op, spr_hi, illegal, pr, exp_trap, exp_cause}
    typedef struct packed {
        logic [3:0] op;
        logic       sh;
        logic       ill;
        logic       pr;
        logic       etrap;
        logic [1:0] ecause;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00},  // R8 plain op in problem state
        '{4'd2, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01},  // R2
        '{4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01},  // R2
        '{4'd4, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01},  // R2
        '{4'd5, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01},  // R2
        '{4'd1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01},  // R2 attention trapped
        '{4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00},  // R2 supervisor ok
        '{4'd6, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00},  // R3
        '{4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00},  // R3
        '{4'd6, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01},  // R3
        '{4'd7, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01},  // R3
        '{4'd7, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00},  // R3 supervisor
        '{4'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10},  // R4
        '{4'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10},  // R4
        '{4'd3, 1'b0, 1'b1, 1'b1, 1'b1, 2'b01},  // R4 priority
        '{4'd7, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10}   // R4
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic sh, input logic ill,
                         input logic [63:0] a, input logic [63:0] m);
        @(negedge clk);
        op_class = op; spr_hi = sh; illegal = ill; cia = a; msr_in = m;
        issue_valid = 1;
        @(negedge clk);
        issue_valid = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
        $finish;
    end

    initial begin
        logic [63:0] sa_prev, ss_prev;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 res_valid", {63'd0, res_valid}, 64'd0);
        chk("R1 trap", {63'd0, trap}, 64'd0);
        chk("R1 halted", {63'd0, halted}, 64'd0);
        chk("R1 nia", nia, 64'd0);
        chk("R1 save_state", save_state, 64'd0);
        @(negedge clk) rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            logic [63:0] a, m, exp_ss;
            a = 64'h1000 + 64'(i) * 64'h40;
            m = ((i % 2) ? 64'hAAAA_AAAA_AAAA_AAAA : 64'h5555_5555_5555_5555);
            m[14] = VEC[i].pr;
            sa_prev = save_addr;
            ss_prev = save_state;
            issue(VEC[i].op, VEC[i].sh, VEC[i].ill, a, m);
            chk($sformatf("R11 valid v%0d", i), {63'd0, res_valid}, 64'd1);
            chk($sformatf("R2 R3 R4 trap v%0d", i), {63'd0, trap}, {63'd0, VEC[i].etrap});
            chk($sformatf("R4 cause v%0d", i), {62'd0, trap_cause}, {62'd0, VEC[i].ecause});
            if (VEC[i].etrap) begin
                exp_ss = m;
                if (VEC[i].ecause[0]) exp_ss[18] = 1'b1;
                if (VEC[i].ecause[1]) exp_ss[19] = 1'b1;
                chk($sformatf("R6 nia v%0d", i), nia, 64'h700);
                chk($sformatf("R5 save_addr v%0d", i), save_addr, a);
                chk($sformatf("R5 save_state v%0d", i), save_state, exp_ss);
                chk($sformatf("R7 msr_out v%0d", i), msr_out, (m & ~CLR) | SET);
            end else begin
                chk($sformatf("R8 nia v%0d", i), nia, a + 64'd4);
                chk($sformatf("R8 msr_out v%0d", i), msr_out, m);
                chk($sformatf("R8 save_addr v%0d", i), save_addr, sa_prev);
                chk($sformatf("R8 save_state v%0d", i), save_state, ss_prev);
            end
            @(negedge clk);
            chk($sformatf("R11 pulse v%0d", i), {63'd0, res_valid}, 64'd0);
        end

        // R7 all-ones and all-zeros state words
        issue(4'd0, 0, 1, 64'h2000, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R7 ones", msr_out, ~CLR);
        issue(4'd0, 0, 1, 64'h2004, 64'd0);
        chk("R7 zeros", msr_out, SET);
        chk("R5 zeros saved", save_state, 64'h0000_0000_0008_0000);

        // R9 attention in supervisor, even with illegal set
        sa_prev = save_addr;
        issue(4'd1, 0, 1, 64'h3000, 64'h1234_0000_0000_0000);
        chk("R9 halted", {63'd0, halted}, 64'd1);
        chk("R9 no trap", {63'd0, trap}, 64'd0);
        chk("R9 nia", nia, 64'h3000);
        chk("R9 save_addr", save_addr, sa_prev);

        // R10 ignored while halted
        issue(4'd0, 0, 1, 64'h4000, 64'h0000_0000_0000_4000);
        chk("R10 no valid", {63'd0, res_valid}, 64'd0);
        chk("R10 nia hold", nia, 64'h3000);
        chk("R10 msr hold", msr_out, 64'h1234_0000_0000_0000);
        chk("R10 still halted", {63'd0, halted}, 64'd1);

        // R1 reset clears halt
        @(negedge clk) rst_n = 0;
        @(negedge clk) rst_n = 1;
        chk("R1 halt cleared", {63'd0, halted}, 64'd0);
        issue(4'd0, 0, 0, 64'h5000, 64'd0);
        chk("R8 after reset", nia, 64'h5004);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule